// File: doc/BRIEF.md
# Block-Bypass Binary Adder/Subtractor

This block adds or subtracts two unsigned words in pure combinational logic. The word is cut into equal slices. Inside each slice the carry moves bit by bit. Each slice also has a bypass multiplexer. When every bit of a slice would only pass an incoming carry along, the multiplexer hands that incoming carry straight to the next slice. The longest carry path then becomes: a ripple across the lowest slice, one multiplexer hop for each middle slice, and a ripple across the top slice.

A mode input selects subtraction. In that mode every bit of the second operand is inverted and the low-order carry is forced to one, so the result is the two's-complement difference. The carry-out then reads as "no borrow". Both the word width and the slice width are parameters. Elaboration refuses any width that is not a whole number of slices. Under unit gate delays the best slice width is roughly the square root of half the word width.

Top module: `csk_adder`

## Requirements
- R1: In add mode (`sub_en`=0), {`co`,`sum`} equals `opa` + `opb` + `ci`, computed as a WIDTH+1 bit unsigned value.
- R2: In subtract mode (`sub_en`=1), `sum` equals `opa` − `opb` modulo 2^WIDTH. `co` is 1 exactly when `opa` ≥ `opb` as unsigned numbers.
- R3: In subtract mode the value on `ci` has no effect on `sum` or `co`.
- R4: When `opa` XOR `opb` is all ones in add mode, `co` equals `ci` and every bit of `sum` equals the inverse of `ci`.
- R5: A carry generated in bit 0 while all higher bits propagate (for example 16'hFFFF + 16'h0001) reaches `co` and leaves `sum` all zeros.
- R6: For every slice whose bits all propagate, the carry leaving the slice equals the carry entering it. A carry generated in a lower slice therefore crosses an all-propagate slice unchanged (for example 16'h00FF + 16'h0001 = 16'h0100 with 4-bit slices).
- R7: WIDTH must be a positive whole multiple of BLK. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand (minuend when subtracting) |
| opb | input | WIDTH | Second operand (subtrahend when subtracting) |
| ci | input | 1 | Carry into bit 0; used only in add mode |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| sum | output | WIDTH | Sum or difference |
| co | output | 1 | Carry out of the top bit (no-borrow flag when subtracting) |

## Verification
Two functions can act on the same result at once: internal ripple inside a slice and the bypass across whole slices. This happens when a carry born in a low slice has to cross one or more slices whose bits all propagate. The bench provokes it with operands such as 16'h00FF + 16'h0001, 16'h0FFF + 16'h0001 and 16'hFFFF + 16'h0001. It judges the outcome by the result at the ports, compared against a behavioural sum. A bound checker also compares each slice's outgoing carry with its incoming carry whenever that slice's propagate signal is high. Subtract mode is exercised together with both values of `ci`, to show that the carry-in is overridden.

// File: rtl/csk_pkg.sv
package csk_pkg;
   // number of equal slices a word of w bits splits into
   function automatic int unsigned slice_count(input int unsigned w, input int unsigned b);
      return w / b;
   endfunction

   // width of the remainder; any value other than zero is an illegal setting
   function automatic int unsigned slice_rem(input int unsigned w, input int unsigned b);
      return w % b;
   endfunction
endpackage

// File: rtl/csk_operand.sv
module csk_operand #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             ci,
   input  logic             sub_en,
   output logic [WIDTH-1:0] gen,
   output logic [WIDTH-1:0] prop,
   output logic             c0
);
   logic [WIDTH-1:0] b_eff;

   // invert the second operand bitwise when subtracting
   always_comb begin
      for (int k = 0; k < WIDTH; k++) begin
         b_eff[k] = opb[k] ^ sub_en;
      end
   end

   assign gen  = opa & b_eff;
   assign prop = opa ^ b_eff;
   // subtract mode forces the low-order carry high regardless of ci
   assign c0   = sub_en | ci;
endmodule

// File: rtl/csk_block.sv
module csk_block #(
   parameter int unsigned BLK = 4
) (
   input  logic [BLK-1:0] gen,
   input  logic [BLK-1:0] prop,
   input  logic           c_in,
   output logic [BLK-1:0] sum,
   output logic           c_out,
   output logic           bp
);
   logic [BLK:0] chain;

   assign chain[0] = c_in;

   genvar i;
   generate
      for (i = 0; i < BLK; i++) begin : g_rip
         assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
      end
   endgenerate

   assign sum = prop ^ chain[BLK-1:0];
   assign bp  = &prop;
   // bypass multiplexer: an all-propagate slice forwards its input carry
   assign c_out = bp ? c_in : chain[BLK];
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned BLK   = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             ci,
   input  logic             sub_en,
   output logic [WIDTH-1:0] sum,
   output logic             co
);
   import csk_pkg::*;

   localparam int unsigned NSLC = slice_count(WIDTH, BLK);

   // R7: reject widths that are not a whole number of slices
   generate
      if (BLK == 0 || WIDTH == 0 || slice_rem(WIDTH, BLK) != 0) begin : g_badcfg
         $error("csk_adder: WIDTH must be a positive multiple of BLK");
      end
   endgenerate

   logic [WIDTH-1:0] gen;
   logic [WIDTH-1:0] prop;
   logic [NSLC:0]    slc_c;
   logic [NSLC-1:0]  slc_bp;

   csk_operand #(.WIDTH(WIDTH)) u_opnd (
      .opa    (opa),
      .opb    (opb),
      .ci     (ci),
      .sub_en (sub_en),
      .gen    (gen),
      .prop   (prop),
      .c0     (slc_c[0])
   );

   genvar s;
   generate
      for (s = 0; s < NSLC; s++) begin : g_slc
         csk_block #(.BLK(BLK)) u_blk (
            .gen   (gen[s*BLK +: BLK]),
            .prop  (prop[s*BLK +: BLK]),
            .c_in  (slc_c[s]),
            .sum   (sum[s*BLK +: BLK]),
            .c_out (slc_c[s+1]),
            .bp    (slc_bp[s])
         );
      end
   endgenerate

   assign co = slc_c[NSLC];
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned BLK   = 4,
   localparam int unsigned NSLC = WIDTH / BLK
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             ci,
   input logic             sub_en,
   input logic [WIDTH-1:0] sum,
   input logic             co,
   input logic [NSLC:0]    slc_c,
   input logic [NSLC-1:0]  slc_bp
);
   logic [WIDTH:0] ref_add;
   logic [WIDTH:0] ref_sub;

   always_comb begin
      ref_add = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ci};
      ref_sub = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, 1'b1};
      if (!$isunknown({opa, opb, ci, sub_en, sum, co, slc_c, slc_bp})) begin
         // R1
         add_result_chk: assert (sub_en || {co, sum} == ref_add)
            else $error("add result mismatch");
         // R2
         sub_result_chk: assert (!sub_en || (sum == opa - opb && co == (opa >= opb)))
            else $error("subtract result mismatch");
         // R3
         sub_cin_chk: assert (!sub_en || {co, sum} == ref_sub)
            else $error("carry-in leaked into subtraction");
         // R4
         full_prop_chk: assert (sub_en || (opa ^ opb) != '1 || (co == ci && sum == {WIDTH{~ci}}))
            else $error("all-propagate word did not pass carry");
         for (int s = 0; s < NSLC; s++) begin
            // R6
            slice_bypass_chk: assert (!slc_bp[s] || slc_c[s+1] == slc_c[s])
               else $error("slice bypass carry mismatch");
         end
      end
   end
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
   .opa    (opa),
   .opb    (opb),
   .ci     (ci),
   .sub_en (sub_en),
   .sum    (sum),
   .co     (co),
   .slc_c  (slc_c),
   .slc_bp (slc_bp)
);

// File: tb/tb_csk_adder.sv
module tb_csk_adder;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         c;
      logic         sb;
      logic [W-1:0] s;
      logic         co;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
      '{16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1},
      '{16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555, 1'b0},
      '{16'h8000, 16'h8000, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{16'h0005, 16'h0003, 1'b0, 1'b1, 16'h0002, 1'b1},
      '{16'h0003, 16'h0005, 1'b0, 1'b1, 16'hFFFE, 1'b0},
      '{16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1},
      '{16'h00FF, 16'h0001, 1'b0, 1'b0, 16'h0100, 1'b0},
      '{16'h0FFF, 16'h0001, 1'b0, 1'b0, 16'h1000, 1'b0},
      '{16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000, 1'b0},
      '{16'hAAAA, 16'h5555, 1'b1, 1'b0, 16'h0000, 1'b1},
      '{16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF, 1'b0},
      '{16'h0003, 16'h0005, 1'b1, 1'b1, 16'hFFFE, 1'b0}
   };

   logic         clk = 1'b0;
   logic [W-1:0] opa, opb, sum;
   logic         ci, sub_en, co;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csk_adder #(.WIDTH(W), .BLK(4)) dut (
      .opa(opa), .opb(opb), .ci(ci), .sub_en(sub_en), .sum(sum), .co(co)
   );

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input logic sb);
      @(negedge clk);
      opa = a; opb = b; ci = c; sub_en = sb;
      #(CLK_PERIOD/4);
   endtask

   task automatic check(input string req, input logic [W-1:0] es, input logic ec);
      checks++;
      if (sum !== es || co !== ec) begin
         errors++;
         $display("FAIL %s a=%h b=%h ci=%b sub=%b got %b_%h exp %b_%h",
                  req, opa, opb, ci, sub_en, co, sum, ec, es);
      end
   endtask

   initial begin
      logic [W:0] ref_v;
      logic [W:0] keep;
      opa = '0; opb = '0; ci = 1'b0; sub_en = 1'b0;

      // table walk: R1 R2 R3 R4 R5 R6 vectors
      for (int i = 0; i < NV; i++) begin
         apply(TBL[i].a, TBL[i].b, TBL[i].c, TBL[i].sb);
         check(TBL[i].sb ? "R2" : "R1", TBL[i].s, TBL[i].co);
      end

      // R5: carry born in bit 0 crosses every slice
      apply(16'hFFFF, 16'h0001, 1'b0, 1'b0);
      check("R5", 16'h0000, 1'b1);

      // R6: carry from slice 0 crosses all-propagate slices 1 and 2
      apply(16'h0F0F, 16'h00F1, 1'b0, 1'b0);
      check("R6", 16'h1000, 1'b0);

      // R4: all-propagate words, both carry-in values
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] a;
         a = W'($urandom);
         apply(a, ~a, i[0], 1'b0);
         check("R4", {W{~i[0]}}, i[0]);
      end

      // R3: subtraction result identical for both carry-in values
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] a, b;
         a = W'($urandom); b = W'($urandom);
         apply(a, b, 1'b0, 1'b1);
         keep = {co, sum};
         apply(a, b, 1'b1, 1'b1);
         check("R3", keep[W-1:0], keep[W]);
      end

      // R1 / R2: random operands against behavioural arithmetic
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] a, b;
         logic c, sb;
         a = W'($urandom); b = W'($urandom);
         c = 1'($urandom); sb = 1'($urandom);
         apply(a, b, c, sb);
         if (sb) begin
            check("R2", a - b, a >= b);
         end else begin
            ref_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
            check("R1", ref_v[W-1:0], ref_v[W]);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule